// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and records how they relate as a 2-bit condition code in a floating-point status word. A caller presents both operands, a precision select, a field select and the current status word, then pulses `start`. One cycle later `done` pulses and `stat_out` holds the updated status word. Each operation can use 32-bit or 64-bit operands.

Four condition fields sit in the status word, and the field select chooses which one receives the code. An unordered result happens when either operand is a NaN. In that case the block checks a trap-enable bit in the incoming status word. If the bit is set, the block raises a trap request. If it is clear, the block sets a sticky invalid flag instead. The other bits of the status word pass through unchanged. The block does no rounding and no arithmetic.

Top module: `fp_cmp_cc`

## Requirements
- R1: The relation code is two bits: 00 equal, 01 a less than b, 10 a greater than b, 11 unordered.
- R2: Both bits of the selected field are cleared and then hold the new code, whatever they held before.
- R3: All status bits other than the selected field and the invalid flag (bit 9) equal the incoming status word.
- R4: Field select 0, 1, 2, 3 places the code's low bit at status bit 10, 32, 34, 36 (base 10 plus offset 0, 22, 24, 26).
- R5: An unordered result with trap-enable (status bit 27) set pulses `trap_req` together with `done` and leaves bit 9 as it came in.
- R6: An unordered result with trap-enable clear sets bit 9 and keeps `trap_req` low. Bit 9 is never cleared by an operation.
- R7: With `dbl` = 0 only bits [31:0] of each operand are used, as a 32-bit format, and the upper bits have no effect. With `dbl` = 1 all 64 bits are used.
- R8: An operand whose exponent is all ones and whose fraction is nonzero is a NaN and gives an unordered result. An infinity is not a NaN and is ordered.
- R9: +0 and -0 compare equal.
- R10: Negative values are ordered by reversed magnitude, and any negative value is less than any non-negative one.
- R11: `done` is high exactly in the cycle after a `start` cycle. `stat_out` changes only in that cycle and otherwise holds its value. After reset `stat_out`, `done` and `trap_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a compare in this cycle |
| dbl | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit operands |
| fld_sel | input | 2 | Condition field select |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| stat_in | input | 64 | Current status word |
| stat_out | output | 64 | Updated status word, valid when `done` is high |
| trap_req | output | 1 | Trap request on an unordered result with trap-enable set |
| done | output | 1 | Completion pulse |

## Verification
The assertions check several rules on every cycle:
- `done` follows `start` by one cycle.
- Status bits outside the chosen field and the invalid flag come through unchanged.
- A trap request appears only with `done` and only when trap-enable was set.
- The sticky flag is never lost.

Only the bench's scenarios can show the rest:
- that the actual code values are correct across the relations,
- the field positions,
- NaN versus infinity,
- equality of signed zeros,
- reversed ordering of negative values,
- that the upper operand bits are ignored in 32-bit mode.

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc #(
  parameter int W       = 64,
  parameter int CC_BASE = 10,
  parameter int TE_BIT  = 27,
  parameter int NV_BIT  = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         dbl,
  input  logic [1:0]   fld_sel,
  input  logic [63:0]  op_a,
  input  logic [63:0]  op_b,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] stat_out,
  output logic         trap_req,
  output logic         done
);

  localparam logic [W-1:0] NV_MASK = {{(W-1){1'b0}}, 1'b1} << NV_BIT;

  function automatic int fld_pos(input logic [1:0] s);
    return (s == 2'd0) ? CC_BASE : CC_BASE + 20 + 2 * int'(s);
  endfunction

  function automatic logic is_nan(input logic [63:0] v, input logic d);
    if (d) return (&v[62:52]) && (|v[51:0]);
    return (&v[30:23]) && (|v[22:0]);
  endfunction

  logic        sa, sb, nan_any, unord, te;
  logic [62:0] ma, mb;
  logic [1:0]  rel;
  logic [W-1:0] fmask, code_w, nxt;

  assign sa = dbl ? op_a[63] : op_a[31];
  assign sb = dbl ? op_b[63] : op_b[31];
  assign ma = dbl ? op_a[62:0] : {32'b0, op_a[30:0]};
  assign mb = dbl ? op_b[62:0] : {32'b0, op_b[30:0]};
  assign nan_any = is_nan(op_a, dbl) || is_nan(op_b, dbl);

  always_comb begin
    if (nan_any)                      rel = 2'b11;
    else if (ma == 63'd0 && mb == 63'd0) rel = 2'b00;
    else if (sa != sb)                rel = sa ? 2'b01 : 2'b10;
    else if (ma == mb)                rel = 2'b00;
    else if ((ma < mb) ^ sa)          rel = 2'b01;
    else                              rel = 2'b10;
  end

  assign unord  = (rel == 2'b11);
  assign te     = stat_in[TE_BIT];
  assign fmask  = {{(W-2){1'b0}}, 2'b11} << fld_pos(fld_sel);
  assign code_w = {{(W-2){1'b0}}, rel} << fld_pos(fld_sel);
  assign nxt    = (stat_in & ~fmask) | code_w | ((unord && !te) ? NV_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_out <= '0;
      trap_req <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= start;
      trap_req <= start && unord && te;
      if (start) stat_out <= nxt;
    end
  end

  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(stat_out));
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (((stat_out ^ $past(stat_in)) & ~($past(fmask) | NV_MASK)) == '0));
  a_r5_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> done && $past(stat_in[TE_BIT]) && $past(unord));
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    start && stat_in[NV_BIT] |=> stat_out[NV_BIT]);
  a_r6_flag_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    start && unord && !te |=> stat_out[NV_BIT] && !trap_req);

endmodule

// File: tb/fp_cmp_cc_bench.sv
module fp_cmp_cc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dbl = 1'b0;
  logic [1:0]  fld_sel = 2'd0;
  logic [63:0] op_a = '0, op_b = '0, stat_in = '0;
  logic [63:0] stat_out;
  logic        trap_req, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_cmp_cc u_fp_cmp_cc (.clk, .rst_n, .start, .dbl, .fld_sel, .op_a, .op_b,
                         .stat_in, .stat_out, .trap_req, .done);

  localparam logic [63:0] TE = 64'd1 << 27;
  localparam logic [63:0] NV = 64'd1 << 9;
  localparam logic [63:0] S1 = 64'h3F80_0000, S2 = 64'h4000_0000;
  localparam logic [63:0] SM1 = 64'hBF80_0000, SM2 = 64'hC000_0000;
  localparam logic [63:0] SNAN = 64'h7FC0_0000, SINF = 64'h7F80_0000;
  localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] DM2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000, DINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] PRE = 64'h0000_003F_0000_0C00;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int pos_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 32;
      2'd2: return 34;
      default: return 36;
    endcase
  endfunction

  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic d, input logic [1:0] s, input logic [63:0] st,
                     input logic [1:0] code, input bit exp_trap);
    logic [63:0] exp;
    exp = (st & ~(64'd3 << pos_of(s))) | (64'(code) << pos_of(s));
    if (code == 2'b11 && !st[27]) exp = exp | NV;
    @(negedge clk);
    op_a = a; op_b = b; dbl = d; fld_sel = s; stat_in = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, {req, " done"}, 64'(done), 64'd1);
    check(stat_out === exp, req, stat_out, exp);
    check(trap_req === exp_trap, {req, " trap"}, 64'(trap_req), 64'(exp_trap));
    stat_in = ~st;
    @(negedge clk);
    check(done === 1'b0 && stat_out === exp, {"R11 hold after ", req}, stat_out, exp);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check(stat_out === '0 && done === 1'b0 && trap_req === 1'b0, "R11 reset", stat_out, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_codes();
    run("R1 eq",   S1, S1, 1'b0, 2'd0, 64'd0, 2'b00, 1'b0);
    run("R1 lt",   S1, S2, 1'b0, 2'd0, 64'd0, 2'b01, 1'b0);
    run("R1 gt",   S2, S1, 1'b0, 2'd0, 64'd0, 2'b10, 1'b0);
    run("R2 overwrite", S1, S1, 1'b0, 2'd0, PRE, 2'b00, 1'b0);
  endtask

  task automatic t_fields();
    run("R4 fld1", S1, S2, 1'b0, 2'd1, PRE, 2'b01, 1'b0);
    run("R4 fld2", S2, S1, 1'b0, 2'd2, PRE, 2'b10, 1'b0);
    run("R4 fld3", S1, S2, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_F1FF & ~TE, 2'b01, 1'b0);
    run("R3 others kept", S1, S1, 1'b0, 2'd3, 64'hA5A5_5A5A_1234_5A5A & ~TE & ~NV, 2'b00, 1'b0);
  endtask

  task automatic t_unordered();
    run("R5 trap", SNAN, S1, 1'b0, 2'd1, TE, 2'b11, 1'b1);
    run("R6 flag", S1, SNAN, 1'b0, 2'd2, 64'd0, 2'b11, 1'b0);
    run("R6 sticky", S1, S2, 1'b0, 2'd0, NV, 2'b01, 1'b0);
    run("R8 dbl nan", DNAN, D1, 1'b1, 2'd0, 64'd0, 2'b11, 1'b0);
    run("R8 inf ordered", SINF, S2, 1'b0, 2'd0, 64'd0, 2'b10, 1'b0);
    run("R8 dbl inf", D2, DINF, 1'b1, 2'd3, 64'd0, 2'b01, 1'b0);
  endtask

  task automatic t_signs();
    run("R9 zeros", 64'h0, 64'h8000_0000, 1'b0, 2'd0, 64'd0, 2'b00, 1'b0);
    run("R9 dbl zeros", 64'h8000_0000_0000_0000, 64'h0, 1'b1, 2'd1, 64'd0, 2'b00, 1'b0);
    run("R10 neg rev", SM2, SM1, 1'b0, 2'd0, 64'd0, 2'b01, 1'b0);
    run("R10 neg lt pos", SM1, S1, 1'b0, 2'd2, 64'd0, 2'b01, 1'b0);
    run("R10 dbl neg", D1, DM2, 1'b1, 2'd0, 64'd0, 2'b10, 1'b0);
  endtask

  task automatic t_precision();
    run("R7 upper ignored", {32'hFFFF_FFFF, S1[31:0]}, {32'h7FF8_0000, S1[31:0]}, 1'b0, 2'd0, 64'd0, 2'b00, 1'b0);
    run("R7 dbl uses all", D2, D1, 1'b1, 2'd1, 64'd0, 2'b10, 1'b0);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_fields();
    t_unordered();
    t_signs();
    t_precision();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule